// File: doc/BRIEF.md
# Shared-Unit Multicycle Datapath

This block is the 32-bit data path of a small multicycle processor. It runs register-to-register arithmetic, word loads, word stores, equality branches and absolute jumps. Each instruction is spread over several clock cycles. A single memory port and a single ALU are reused from one cycle to the next. Values that one step produces for a later step are kept in holding registers that software cannot see: the instruction word, the loaded data word, the two register operands and the ALU result.

An external sequencer drives all strobes and multiplexer selects, one set per cycle. It reads back the opcode field of the held instruction and the zero flag of the live ALU result. The memory sits outside the block. It has a combinational read and a write that takes effect at the clock edge, and the block addresses it with byte addresses that are word aligned.

Top module: `mc_datapath`

## Requirements
- R1: After reset the PC, every holding register and every architectural register are zero. With all controls low, `mem_addr` is 0, `opcode` is 0 and `zero` is 1.
- R2: `mem_addr` carries the PC when `addr_sel` is 0 and the registered ALU result when it is 1.
- R3: The instruction word loads from `mem_rdata` only at an edge where `ir_wr` is high. `opcode` shows bits 31:26 of the held word and stays unchanged otherwise. Opcodes used: 0 register op, 2 jump, 4 branch-if-equal, 35 load, 43 store.
- R4: The first ALU operand is the PC (`srca_sel`=0) or operand A (`srca_sel`=1). The second is operand B (`srcb_sel`=0), the constant 4 (1), the sign-extended bits 15:0 (2) or that value shifted left by two (3).
- R5: The PC loads at an edge when `pc_wr` is high, or when `pc_wr_cond` and `zero` are both high. `pc_sel` picks the value: 0 live ALU result, 1 registered ALU result, 2 jump target = {PC[31:28], bits 25:0, 2'b00}.
- R6: `alu_mode` 0 adds and 1 subtracts. `alu_mode` 2 decodes bits 5:0: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0).
- R7: A register write (`rf_wr`) goes to bits 15:11 when `dst_sel`=1 and to bits 20:16 when `dst_sel`=0. It writes the registered ALU result when `wb_sel`=0 and the held memory data when `wb_sel`=1. Operand A reads register bits 25:21 and B reads bits 20:16, both loading on every edge.
- R8: Register 0 always reads as zero, and a write to it has no effect.
- R9: `mem_wdata` is operand B, and `mem_we` follows `mem_wr`.
- R10: `zero` is high exactly when the live ALU result is zero, so a subtract of equal operands qualifies a conditional PC load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load qualified by zero |
| addr_sel | input | 1 | Memory address select: PC / ALU result register |
| mem_wr | input | 1 | Memory write strobe |
| ir_wr | input | 1 | Instruction register load |
| wb_sel | input | 1 | Write-back source: ALU result / memory data |
| pc_sel | input | 2 | PC source select |
| alu_mode | input | 2 | ALU operation class |
| srcb_sel | input | 2 | Second ALU operand select |
| srca_sel | input | 1 | First ALU operand select |
| rf_wr | input | 1 | Register file write |
| dst_sel | input | 1 | Destination register field select |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| opcode | output | 6 | Opcode of the held instruction |
| zero | output | 1 | Live ALU result is zero |

## Verification
The bench builds the block with its default reset PC of zero and the full 32-entry register file, so register 0 and the highest register indices are both reachable. It plays the sequencer itself and runs a program that touches every ALU function, signed comparison with a negative operand, taken and untaken branches, a backward branch with a negative offset, a jump and a discarded write to register 0. The fetch address, opcode, store traffic and zero flag are compared with an instruction-level model on every step, and the stored results are compared at the end.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN = 32;
    localparam int RAW  = 5;
    localparam int NREG = 1 << RAW;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] mdr;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] aluout;
    } hold_t;
endpackage

// File: rtl/mc_alu_dec.sv
module mc_alu_dec
    import mc_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [5:0] funct,
    output alu_op_e    op
);
    always_comb begin
        op = ALU_ADD;
        unique case (mode)
            2'b01: op = ALU_SUB;
            2'b10: begin
                unique case (funct)
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: op = ALU_ADD;
                endcase
            end
            default: op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         is_zero
);
    always_comb begin
        unique case (op)
            ALU_SUB: res = a - b;
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_SLT: res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: res = a + b;
        endcase
        is_zero = (res == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr0,
    input  logic [AW-1:0] raddr1,
    output logic [W-1:0]  rdata0,
    output logic [W-1:0]  rdata1
);
    localparam int N = 1 << AW;

    logic [W-1:0] rf_q [N];
    logic [W-1:0] rf_d [N];

    always_comb begin
        rf_d = rf_q;
        if (we && (waddr != '0)) begin
            rf_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                rf_q[i] <= '0;
            end
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata0 = (raddr0 == '0) ? '0 : rf_q[raddr0];
    assign rdata1 = (raddr1 == '0) ? '0 : rf_q[raddr1];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_wr,
    input  logic            pc_wr_cond,
    input  logic            addr_sel,
    input  logic            mem_wr,
    input  logic            ir_wr,
    input  logic            wb_sel,
    input  logic [1:0]      pc_sel,
    input  logic [1:0]      alu_mode,
    input  logic [1:0]      srcb_sel,
    input  logic            srca_sel,
    input  logic            rf_wr,
    input  logic            dst_sel,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    output logic [5:0]      opcode,
    output logic            zero
);
    localparam int IMM_W = 16;
    localparam int JMP_W = 26;

    hold_t st_q, st_d;

    logic [XLEN-1:0] rd0, rd1;
    logic [XLEN-1:0] alu_a, alu_b, alu_res;
    logic [XLEN-1:0] imm_ext, imm_sh, jmp_tgt, pc_next, wval;
    logic [RAW-1:0]  wdst;
    logic            alu_z, pc_load;
    logic [XLEN-1:0] pc_cur;
    alu_op_e         op;

    assign pc_cur  = st_q.pc;
    assign imm_ext = {{(XLEN-IMM_W){st_q.ir[IMM_W-1]}}, st_q.ir[IMM_W-1:0]};
    assign imm_sh  = {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_tgt = {st_q.pc[XLEN-1:XLEN-4], st_q.ir[JMP_W-1:0], 2'b00};
    assign wdst    = dst_sel ? st_q.ir[15:11] : st_q.ir[20:16];
    assign wval    = wb_sel ? st_q.mdr : st_q.aluout;

    mc_regfile #(.W(XLEN), .AW(RAW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_wr),
        .waddr  (wdst),
        .wdata  (wval),
        .raddr0 (st_q.ir[25:21]),
        .raddr1 (st_q.ir[20:16]),
        .rdata0 (rd0),
        .rdata1 (rd1)
    );

    always_comb begin
        alu_a = srca_sel ? st_q.a : st_q.pc;
        unique case (srcb_sel)
            2'b00:   alu_b = st_q.b;
            2'b01:   alu_b = XLEN'(4);
            2'b10:   alu_b = imm_ext;
            default: alu_b = imm_sh;
        endcase
    end

    mc_alu_dec u_dec (
        .mode  (alu_mode),
        .funct (st_q.ir[5:0]),
        .op    (op)
    );

    mc_alu #(.W(XLEN)) u_alu (
        .a       (alu_a),
        .b       (alu_b),
        .op      (op),
        .res     (alu_res),
        .is_zero (alu_z)
    );

    always_comb begin
        unique case (pc_sel)
            2'b01:   pc_next = st_q.aluout;
            2'b10:   pc_next = jmp_tgt;
            default: pc_next = alu_res;
        endcase
        pc_load = pc_wr | (pc_wr_cond & alu_z);
    end

    always_comb begin
        st_d        = st_q;
        st_d.mdr    = mem_rdata;
        st_d.a      = rd0;
        st_d.b      = rd1;
        st_d.aluout = alu_res;
        if (ir_wr) begin
            st_d.ir = mem_rdata;
        end
        if (pc_load) begin
            st_d.pc = pc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = addr_sel ? st_q.aluout : st_q.pc;
    assign mem_wdata = st_q.b;
    assign mem_we    = mem_wr;
    assign opcode    = st_q.ir[31:26];
    assign zero      = alu_z;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pc_wr,
    input logic        pc_wr_cond,
    input logic        ir_wr,
    input logic        zero,
    input logic        srca_sel,
    input logic [1:0]  pc_sel,
    input logic [1:0]  srcb_sel,
    input logic [1:0]  alu_mode,
    input logic [5:0]  opcode,
    input logic [31:0] pc_cur
);
    p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable(opcode));

    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && !pc_wr_cond) |=> $stable(pc_cur));

    p_cond_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond && !pc_wr && !zero) |=> $stable(pc_cur));

    p_step_four_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_sel == 2'b00 && !srca_sel && srcb_sel == 2'b01 && alu_mode == 2'b00)
        |=> (pc_cur == $past(pc_cur) + 32'd4));

    p_jump_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_sel == 2'b10) |=> (pc_cur[1:0] == 2'b00));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .ir_wr      (ir_wr),
    .zero       (zero),
    .srca_sel   (srca_sel),
    .pc_sel     (pc_sel),
    .srcb_sel   (srcb_sel),
    .alu_mode   (alu_mode),
    .opcode     (opcode),
    .pc_cur     (pc_cur)
);

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, wb_sel, srca_sel, rf_wr, dst_sel;
    logic [1:0] pc_sel, alu_mode, srcb_sel;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic mem_we, zero;
    logic [5:0] opcode;

    mc_datapath uut (
        .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .addr_sel(addr_sel), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel),
        .pc_sel(pc_sel), .alu_mode(alu_mode), .srcb_sel(srcb_sel),
        .srca_sel(srca_sel), .rf_wr(rf_wr), .dst_sel(dst_sel),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .opcode(opcode), .zero(zero)
    );

    logic [31:0] mem     [256];
    logic [31:0] ref_mem [256];
    logic [31:0] ref_rf  [32];
    logic [31:0] ref_pc;

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rt(input int rs, input int rtv, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rtv), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] it(input logic [5:0] op, input int rs, input int rtv, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rtv), imm};
    endfunction
    function automatic logic [31:0] jt(input logic [25:0] idx);
        return {6'd2, idx};
    endfunction

    function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] x, input logic [31:0] y);
        case (fn)
            6'h22:   return x - y;
            6'h24:   return x & y;
            6'h25:   return x | y;
            6'h2A:   return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return x + y;
        endcase
    endfunction

    task automatic idle();
        pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; mem_wr = 0; ir_wr = 0; wb_sel = 0;
        pc_sel = 0; alu_mode = 0; srcb_sel = 0; srca_sel = 0; rf_wr = 0; dst_sel = 0;
    endtask

    task automatic put(input int i, input logic [31:0] w);
        mem[i] = w;
        ref_mem[i] = w;
    endtask

    localparam logic [5:0] LW = 6'd35, SW = 6'd43, BEQ = 6'd4;

    initial begin
        #(200000 * 10);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ins, va, vb, npc, ea, res;
        logic [5:0] op, fn;
        int rs, rtf, rd;
        idle();
        for (int i = 0; i < 256; i++) put(i, 32'd0);
        for (int i = 0; i < 32; i++) ref_rf[i] = 32'd0;
        ref_pc = 32'd0;
        put(64, 32'd7);
        put(65, 32'hFFFF_FFFD);
        put(66, 32'd5);
        put(0,  it(LW, 0, 1, 16'h0100));
        put(1,  it(LW, 0, 2, 16'h0104));
        put(2,  rt(1, 2, 3, 6'h20));
        put(3,  rt(1, 2, 4, 6'h22));
        put(4,  rt(1, 2, 5, 6'h24));
        put(5,  rt(1, 2, 6, 6'h25));
        put(6,  rt(2, 1, 7, 6'h2A));
        put(7,  rt(1, 2, 8, 6'h2A));
        put(8,  rt(1, 1, 0, 6'h20));
        put(9,  it(SW, 0, 0, 16'h0120));
        put(10, it(SW, 0, 3, 16'h0124));
        put(11, it(SW, 0, 4, 16'h0128));
        put(12, it(SW, 0, 5, 16'h012C));
        put(13, it(SW, 0, 6, 16'h0130));
        put(14, it(SW, 0, 7, 16'h0134));
        put(15, it(SW, 0, 8, 16'h0138));
        put(16, it(BEQ, 1, 2, 16'd5));
        put(17, it(LW, 0, 31, 16'h0108));
        put(18, it(BEQ, 31, 31, 16'd2));
        put(19, it(SW, 0, 1, 16'h013C));
        put(20, it(SW, 0, 1, 16'h013C));
        put(21, it(SW, 0, 31, 16'h0140));
        put(22, jt(26'd24));
        put(23, it(SW, 0, 1, 16'h0144));
        put(24, it(SW, 0, 2, 16'h0148));
        put(25, it(BEQ, 0, 0, 16'hFFFF));

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_addr == 32'd0, "R1 reset address", mem_addr, 32'd0);
        chk(opcode == 6'd0, "R1 reset opcode", 32'(opcode), 32'd0);
        chk(zero == 1'b1, "R1 reset zero flag", 32'(zero), 32'd1);
        chk(mem_we == 1'b0, "R9 write enable idle", 32'(mem_we), 32'd0);
        @(posedge clk);

        for (int n = 0; n < 30; n++) begin
            @(negedge clk); idle(); ir_wr = 1; pc_wr = 1; srcb_sel = 2'd1; #1;
            chk(mem_addr == ref_pc, "R2 R5 fetch address", mem_addr, ref_pc);
            ins = ref_mem[ref_pc[9:2]];
            op = ins[31:26]; fn = ins[5:0];
            rs = int'(ins[25:21]); rtf = int'(ins[20:16]); rd = int'(ins[15:11]);
            va = ref_rf[rs]; vb = ref_rf[rtf];
            npc = ref_pc + 32'd4;
            ea = va + {{16{ins[15]}}, ins[15:0]};
            ref_pc = npc;
            @(posedge clk);

            @(negedge clk); idle(); srcb_sel = 2'd3; #1;
            chk(opcode == op, "R3 opcode after fetch", 32'(opcode), 32'(op));
            @(posedge clk);

            case (op)
                6'd0: begin
                    @(negedge clk); idle(); srca_sel = 1; alu_mode = 2'd2;
                    @(posedge clk);
                    @(negedge clk); idle(); dst_sel = 1; rf_wr = 1;
                    @(posedge clk);
                    res = ref_alu(fn, va, vb);
                    if (rd != 0) ref_rf[rd] = res;
                end
                LW, SW: begin
                    @(negedge clk); idle(); srca_sel = 1; srcb_sel = 2'd2;
                    @(posedge clk);
                    @(negedge clk); idle(); addr_sel = 1; mem_wr = (op == SW); #1;
                    chk(mem_addr == ea, "R2 data address", mem_addr, ea);
                    if (op == SW) begin
                        chk(mem_wdata == vb, "R9 store data", mem_wdata, vb);
                        chk(mem_we == 1'b1, "R9 store strobe", 32'(mem_we), 32'd1);
                        ref_mem[ea[9:2]] = vb;
                    end
                    @(posedge clk);
                    if (op == LW) begin
                        @(negedge clk); idle(); wb_sel = 1; rf_wr = 1; #1;
                        chk(opcode == LW, "R3 opcode held", 32'(opcode), 32'(LW));
                        @(posedge clk);
                        if (rtf != 0) ref_rf[rtf] = ref_mem[ea[9:2]];
                    end
                end
                BEQ: begin
                    @(negedge clk); idle(); srca_sel = 1; alu_mode = 2'd1;
                    pc_sel = 2'd1; pc_wr_cond = 1; #1;
                    chk(zero == (va == vb), "R10 branch compare", 32'(zero), 32'(va == vb));
                    @(posedge clk);
                    if (va == vb) ref_pc = npc + {{14{ins[15]}}, ins[15:0], 2'b00};
                end
                6'd2: begin
                    @(negedge clk); idle(); pc_sel = 2'd2; pc_wr = 1;
                    @(posedge clk);
                    ref_pc = {npc[31:28], ins[25:0], 2'b00};
                end
                default: ;
            endcase
        end

        @(negedge clk); idle();
        chk(mem[72] == 32'd0, "R8 register zero ignores write", mem[72], 32'd0);
        chk(mem[73] == 32'd4, "R6 add", mem[73], 32'd4);
        chk(mem[74] == 32'd10, "R6 subtract", mem[74], 32'd10);
        chk(mem[75] == 32'd5, "R6 and", mem[75], 32'd5);
        chk(mem[76] == 32'hFFFF_FFFF, "R6 or", mem[76], 32'hFFFF_FFFF);
        chk(mem[77] == 32'd1, "R6 signed less-than true", mem[77], 32'd1);
        chk(mem[78] == 32'd0, "R6 signed less-than false", mem[78], 32'd0);
        chk(mem[80] == 32'd5, "R7 load write-back to register 31", mem[80], 32'd5);
        chk(mem[79] == 32'd0, "R5 taken branch skipped store", mem[79], 32'd0);
        chk(mem[81] == 32'd0, "R5 jump skipped store", mem[81], 32'd0);
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== ref_mem[i])
                chk(1'b0, $sformatf("R4 R7 memory image word %0d", i), mem[i], ref_mem[i]);
        end
        checks++;
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule